// File: doc/BRIEF.md
# Quaternary Symbol Channel Port

This block sits between the line side of a 2B1Q transceiver and the channel-unit side. On the line side it takes one received quaternary symbol at a time, a sign bit and a magnitude bit. It also hands over each transmit symbol it has collected. On the channel-unit side it moves those symbols in one of four ways, picked by a two-bit mode input. In the two parallel modes a whole symbol crosses at once. In the two serial modes the symbol crosses one bit at a time, on a single data line, paced by a bit clock the block generates. Both serial modes also use the symbol clock as a frame marker.

All timing comes from one fast system clock. A divide counter makes the symbol clock `qclk_o`. One symbol period lasts `2*BIT_DIV` system clocks and holds two bit periods of `BIT_DIV` clocks each. In the parallel slave mode, two external baud clocks pace the transfers. These clocks are frequency-locked to the symbol clock. Each one passes through a synchronizer, and a per-direction select picks its rising or falling edge. A new mode value is applied only at the next symbol boundary.

Top module: `quat_cu_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cu_rq_o`, `line_tx_sym_o` and `line_tx_vld_o` are 0 and `qclk_o` is 1. The active mode is parallel master.
- R2: `qclk_o` repeats every `2*BIT_DIV` clocks. It is high for the first `BIT_DIV` clocks of each symbol, counting from reset release.
- R3: Mode 2'b00 is parallel master. On the clock where `qclk_o` rises, `cu_rq_o` loads `line_rx_sym_i`, with bit 1 the sign and bit 0 the magnitude.
- R4: In parallel master mode, `cu_tq_i` (bit 1 sign, bit 0 magnitude) is captured on the clock where `qclk_o` falls. It appears on `line_tx_sym_o` together with a one-clock `line_tx_vld_o` pulse. `line_tx_sym_o` changes only with that pulse.
- R5: Mode 2'b01 is parallel slave. `cu_rq_o` loads `line_rx_sym_i` two clocks after `rx_baud_i` is sampled at its selected edge: the falling edge when `rx_fall_sel_i` is 1, otherwise the rising edge. The other edge has no effect.
- R6: In parallel slave mode, `cu_tq_i` is captured on the selected edge of `tx_baud_i`, chosen by `tx_fall_sel_i`, with the same two-clock synchronizer delay. It is presented with a `line_tx_vld_o` pulse.
- R7: In serial modes, `cu_rq_o[0]` is a bit clock at twice the symbol rate. It is high for the first `BIT_DIV/2` clocks of each bit period.
- R8: In serial modes, `cu_rq_o[1]` carries the symbol's first bit while `qclk_o` is high and its second bit while it is low. It changes only as `qclk_o` toggles. Mode 2'b10 sends magnitude first and mode 2'b11 sends sign first.
- R9: In serial modes, `cu_tq_i[1]` is sampled at each bit-clock fall. The sample taken while `qclk_o` is high is the symbol's first bit. After the second sample the symbol is presented with a `line_tx_vld_o` pulse, ordered as the mode selects. `cu_tq_i[0]` is ignored.
- R10: A change on `mode_i` takes effect only at the next rising edge of `qclk_o`. The current symbol completes in the old mode.
- R11: Outside parallel slave mode, activity on `rx_baud_i` and `tx_baud_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 parallel master, 01 parallel slave, 10 serial magnitude-first, 11 serial sign-first |
| rx_fall_sel_i | input | 1 | Slave receive baud clock edge: 1 falling, 0 rising |
| tx_fall_sel_i | input | 1 | Slave transmit baud clock edge: 1 falling, 0 rising |
| rx_baud_i | input | 1 | External receive baud clock (asynchronous) |
| tx_baud_i | input | 1 | External transmit baud clock (asynchronous) |
| line_rx_sym_i | input | 2 | Received symbol from line side {sign, magnitude} |
| line_tx_sym_o | output | 2 | Collected transmit symbol {sign, magnitude} |
| line_tx_vld_o | output | 1 | One-clock pulse when line_tx_sym_o is updated |
| cu_tq_i | input | 2 | Channel-unit transmit pins: {sign, magnitude} or {serial data, unused} |
| cu_rq_o | output | 2 | Channel-unit receive pins: {sign, magnitude} or {serial data, bit clock} |
| qclk_o | output | 1 | Symbol-rate clock and serial frame marker |

## Verification
The bench changes `mode_i` every few clocks, in the middle of symbols. A design that switched at once would send a half-old, half-new symbol, or would let the bit clock appear partway through a symbol. In the serial modes it drives random data on the unused transmit pin and checks both bit orders. A design that swapped the order, or that let the unused pin leak into the symbol, would give a wrong transmit symbol. It toggles the external baud clocks while master and serial modes are active, which exposes any missing gating. In slave mode it uses both edge selections, so a design that picks the wrong polarity, or gets the synchronizer depth wrong, updates the outputs one clock or half a symbol off.

// File: rtl/quat_cu_pkg.sv
package quat_cu_pkg;

  typedef enum logic [1:0] {
    CU_PAR_MASTER     = 2'b00,
    CU_PAR_SLAVE      = 2'b01,
    CU_SER_MAG_FIRST  = 2'b10,
    CU_SER_SIGN_FIRST = 2'b11
  } cu_mode_e;

endpackage

// File: rtl/quat_cu_timing.sv
// Divide counter: a bit-period counter plus a symbol-half flag.
// All strobes describe the state the counter enters at the coming edge.
module quat_cu_timing #(
  parameter int BIT_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sym_start_o,
  output logic sym_mid_o,
  output logic bit_fall_o,
  output logic half_o,
  output logic bclk_nxt_o
);
  localparam int CW       = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam int HALF_BIT = BIT_DIV / 2;

  logic [CW-1:0] bp_q, bp_n;
  logic          sh_q, sh_n;

  always_comb begin
    if (bp_q == CW'(BIT_DIV - 1)) begin
      bp_n = '0;
      sh_n = ~sh_q;
    end else begin
      bp_n = bp_q + CW'(1);
      sh_n = sh_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q <= '0;
      sh_q <= 1'b0;
    end else begin
      bp_q <= bp_n;
      sh_q <= sh_n;
    end
  end

  assign sym_start_o = (bp_n == '0) & ~sh_n;
  assign sym_mid_o   = (bp_n == '0) &  sh_n;
  assign bit_fall_o  = (bp_n == CW'(HALF_BIT));
  assign half_o      = sh_n;
  assign bclk_nxt_o  = (bp_n < CW'(HALF_BIT));

endmodule

// File: rtl/quat_cu_edge_sync.sv
// Two-flop synchronizer plus one history flop; reports the chosen edge.
module quat_cu_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], async_i};
  end

  assign edge_o = fall_sel_i ? (~sync_q[1] &  sync_q[2])
                             : ( sync_q[1] & ~sync_q[2]);

endmodule

// File: rtl/quat_cu_rx.sv
module quat_cu_rx
  import quat_cu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cu_mode_e   mode_i,
  input  logic       sym_start_i,
  input  logic       sym_mid_i,
  input  logic       bclk_nxt_i,
  input  logic       slave_edge_i,
  input  logic [1:0] line_sym_i,
  output logic [1:0] rq_o
);
  logic [1:0] hold_q;
  logic       sign_first;

  assign sign_first = (mode_i == CU_SER_SIGN_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_o   <= '0;
      hold_q <= '0;
    end else begin
      case (mode_i)
        CU_PAR_MASTER: if (sym_start_i)  rq_o <= line_sym_i;
        CU_PAR_SLAVE:  if (slave_edge_i) rq_o <= line_sym_i;
        default: begin
          rq_o[0] <= bclk_nxt_i;
          if (sym_start_i) begin
            hold_q  <= line_sym_i;
            rq_o[1] <= sign_first ? line_sym_i[1] : line_sym_i[0];
          end else if (sym_mid_i) begin
            rq_o[1] <= sign_first ? hold_q[0] : hold_q[1];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/quat_cu_tx.sv
module quat_cu_tx
  import quat_cu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cu_mode_e   mode_i,
  input  logic       sym_mid_i,
  input  logic       bit_fall_i,
  input  logic       half_i,
  input  logic       slave_edge_i,
  input  logic [1:0] tq_i,
  output logic [1:0] sym_o,
  output logic       vld_o
);
  logic first_q;
  logic sign_first;

  assign sign_first = (mode_i == CU_SER_SIGN_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o   <= '0;
      vld_o   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      case (mode_i)
        CU_PAR_MASTER: if (sym_mid_i) begin
          sym_o <= tq_i;
          vld_o <= 1'b1;
        end
        CU_PAR_SLAVE: if (slave_edge_i) begin
          sym_o <= tq_i;
          vld_o <= 1'b1;
        end
        default: begin
          if (bit_fall_i && !half_i) begin
            first_q <= tq_i[1];
          end else if (bit_fall_i && half_i) begin
            sym_o <= sign_first ? {first_q, tq_i[1]} : {tq_i[1], first_q};
            vld_o <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/quat_cu_port.sv
module quat_cu_port
  import quat_cu_pkg::*;
#(
  parameter int BIT_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       rx_fall_sel_i,
  input  logic       tx_fall_sel_i,
  input  logic       rx_baud_i,
  input  logic       tx_baud_i,
  input  logic [1:0] line_rx_sym_i,
  output logic [1:0] line_tx_sym_o,
  output logic       line_tx_vld_o,
  input  logic [1:0] cu_tq_i,
  output logic [1:0] cu_rq_o,
  output logic       qclk_o
);
  logic     sym_start, sym_mid, bit_fall, half, bclk_nxt;
  logic     rx_edge, tx_edge;
  cu_mode_e mode_q, mode_eff;

  quat_cu_timing #(.BIT_DIV(BIT_DIV)) u_timing (
    .clk(clk), .rst(rst),
    .sym_start_o(sym_start), .sym_mid_o(sym_mid), .bit_fall_o(bit_fall),
    .half_o(half), .bclk_nxt_o(bclk_nxt)
  );

  quat_cu_edge_sync u_rx_sync (
    .clk(clk), .rst(rst), .async_i(rx_baud_i),
    .fall_sel_i(rx_fall_sel_i), .edge_o(rx_edge)
  );

  quat_cu_edge_sync u_tx_sync (
    .clk(clk), .rst(rst), .async_i(tx_baud_i),
    .fall_sel_i(tx_fall_sel_i), .edge_o(tx_edge)
  );

  // mode is only re-read as a new symbol begins
  assign mode_eff = sym_start ? cu_mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CU_PAR_MASTER;
      qclk_o <= 1'b1;
    end else begin
      mode_q <= mode_eff;
      qclk_o <= ~half;
    end
  end

  quat_cu_rx u_rx (
    .clk(clk), .rst(rst), .mode_i(mode_eff),
    .sym_start_i(sym_start), .sym_mid_i(sym_mid), .bclk_nxt_i(bclk_nxt),
    .slave_edge_i(rx_edge), .line_sym_i(line_rx_sym_i), .rq_o(cu_rq_o)
  );

  quat_cu_tx u_tx (
    .clk(clk), .rst(rst), .mode_i(mode_eff),
    .sym_mid_i(sym_mid), .bit_fall_i(bit_fall), .half_i(half),
    .slave_edge_i(tx_edge), .tq_i(cu_tq_i),
    .sym_o(line_tx_sym_o), .vld_o(line_tx_vld_o)
  );

endmodule

// File: rtl/quat_cu_port_chk.sv
module quat_cu_port_chk #(
  parameter int BIT_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       qclk_o,
  input logic [1:0] cu_rq_o,
  input logic [1:0] line_tx_sym_o,
  input logic       line_tx_vld_o,
  input logic [1:0] mode_q
);
  int   cnt;
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) cnt <= 0;
    else     cnt <= (cnt == 2*BIT_DIV - 1) ? 0 : cnt + 1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (cu_rq_o == 2'b00 && line_tx_sym_o == 2'b00 && !line_tx_vld_o && qclk_o)); // R1

  AST_QCLK_CADENCE: assert property (@(posedge clk) disable iff (rst)
    qclk_o == (cnt < BIT_DIV)); // R2

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_tx_vld_o |=> !line_tx_vld_o); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_tx_vld_o |-> $stable(line_tx_sym_o)); // R4

  AST_BCLK_SERIAL: assert property (@(posedge clk) disable iff (rst)
    mode_q[1] |-> (cu_rq_o[0] == ((cnt % BIT_DIV) < BIT_DIV/2))); // R7

  AST_SERIAL_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (mode_q[1] && $past(mode_q[1]) && cu_rq_o[1] != $past(cu_rq_o[1]))
      |-> (qclk_o != $past(qclk_o))); // R8

  AST_MODE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> (qclk_o && !$past(qclk_o))); // R10

endmodule

bind quat_cu_port quat_cu_port_chk #(.BIT_DIV(BIT_DIV)) u_chk (
  .clk(clk), .rst(rst), .qclk_o(qclk_o), .cu_rq_o(cu_rq_o),
  .line_tx_sym_o(line_tx_sym_o), .line_tx_vld_o(line_tx_vld_o),
  .mode_q(mode_q)
);

// File: tb/quat_cu_port_bench.sv
module quat_cu_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D   = 4;
  localparam int SYM = 2 * D;
  localparam int H   = D / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_in = 2'b00;
  logic       rx_fall = 1'b0, tx_fall = 1'b0;
  logic       rx_baud = 1'b0, tx_baud = 1'b0;
  logic [1:0] lrx = 2'b00, ctq = 2'b00;
  logic [1:0] ltx, crq;
  logic       lvld, qclk;

  always #(CLK_PERIOD/2) clk = ~clk;

  quat_cu_port #(.BIT_DIV(D)) u_quat_cu_port (
    .clk(clk), .rst(rst), .mode_i(mode_in),
    .rx_fall_sel_i(rx_fall), .tx_fall_sel_i(tx_fall),
    .rx_baud_i(rx_baud), .tx_baud_i(tx_baud),
    .line_rx_sym_i(lrx), .line_tx_sym_o(ltx), .line_tx_vld_o(lvld),
    .cu_tq_i(ctq), .cu_rq_o(crq), .qclk_o(qclk)
  );

  int    errors = 0, checks = 0;
  string force_tag = "";
  bit    ext_on = 0;
  int    ext_cnt = 0;

  // reference model state
  int         ph = 0, mmode = 0;
  logic [1:0] mrq = 0, mtx = 0, mhold = 0;
  logic       mvld = 0, mqclk = 1, mfirst = 0;
  logic [3:0] hr = 0, ht = 0;
  bit         was_rst = 1;

  task automatic model_edge();
    int pn, bitpos, emode;
    bit half, rxe, txe;
    if (rst) begin
      ph = 0; mmode = 0; mrq = 0; mtx = 0; mhold = 0;
      mvld = 0; mqclk = 1; mfirst = 0; hr = 0; ht = 0; was_rst = 1;
      return;
    end
    hr = {hr[2:0], rx_baud};
    ht = {ht[2:0], tx_baud};
    rxe = rx_fall ? (!hr[2] && hr[3]) : (hr[2] && !hr[3]);
    txe = tx_fall ? (!ht[2] && ht[3]) : (ht[2] && !ht[3]);
    pn = (ph + 1) % SYM;
    bitpos = pn % D;
    half = (pn >= D);
    emode = (pn == 0) ? int'(mode_in) : mmode;
    mvld = 0;
    case (emode)
      0: begin
        if (pn == 0) mrq = lrx;
        if (pn == D) begin mtx = ctq; mvld = 1; end
      end
      1: begin
        if (rxe) mrq = lrx;
        if (txe) begin mtx = ctq; mvld = 1; end
      end
      default: begin
        mrq[0] = (bitpos < H);
        if (pn == 0) begin
          mhold = lrx;
          mrq[1] = (emode == 3) ? lrx[1] : lrx[0];
        end
        if (pn == D) mrq[1] = (emode == 3) ? mhold[0] : mhold[1];
        if (bitpos == H && !half) mfirst = ctq[1];
        if (bitpos == H && half) begin
          mtx = (emode == 3) ? {mfirst, ctq[1]} : {ctq[1], mfirst};
          mvld = 1;
        end
      end
    endcase
    mqclk = !half;
    mmode = emode;
    ph = pn;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    string trq1, trq0, ttx, tq;
    tq = "R2";
    if (mmode == 0)      begin trq1 = "R3"; trq0 = "R3"; ttx = "R4"; end
    else if (mmode == 1) begin trq1 = "R5"; trq0 = "R5"; ttx = "R6"; end
    else                 begin trq1 = "R8"; trq0 = "R7"; ttx = "R9"; end
    if (force_tag != "") begin trq1 = force_tag; trq0 = force_tag; ttx = force_tag; end
    if (was_rst) begin trq1 = "R1"; trq0 = "R1"; ttx = "R1"; tq = "R1"; end
    chk(crq[1] === mrq[1], trq1, int'(crq[1]), int'(mrq[1]));
    chk(crq[0] === mrq[0], trq0, int'(crq[0]), int'(mrq[0]));
    chk(ltx === mtx, ttx, int'(ltx), int'(mtx));
    chk(lvld === mvld, ttx, int'(lvld), int'(mvld));
    chk(qclk === mqclk, tq, int'(qclk), int'(mqclk));
    if (!rst) was_rst = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      lrx = 2'($urandom);
      ctq = 2'($urandom);
      if (ext_on) begin
        ext_cnt++;
        if (ext_cnt % D == 0) rx_baud = ~rx_baud;
        if (ext_cnt % D == 1) tx_baud = ~tx_baud;
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    step(3);
    rst = 1'b0;
    // R3 R4 parallel master
    step(5 * SYM);
    // R11: baud clocks toggling outside slave mode
    ext_on = 1; force_tag = "R11";
    step(4 * SYM);
    force_tag = "";
    // R5 R6 slave, rising then falling edges
    mode_in = 2'b01;
    step(6 * SYM);
    rx_fall = 1'b1; tx_fall = 1'b1;
    step(6 * SYM);
    rx_fall = 1'b0;
    step(3 * SYM);
    // R7 R8 R9 serial, magnitude first then sign first
    mode_in = 2'b10;
    step(6 * SYM);
    mode_in = 2'b11;
    step(6 * SYM);
    // R10: mode input changed mid-symbol
    force_tag = "R10";
    for (int k = 0; k < 20; k++) begin
      mode_in = 2'($urandom);
      step(3);
    end
    force_tag = "";
    // reset in mid-run, then master again
    mode_in = 2'b00;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(3 * SYM);
    summary();
    $finish;
  end

endmodule